// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and the status words of a 32-bit RISC core that runs in one of seven operating modes. A 4-bit logical register index is resolved against the mode field of the current status word. Low registers are common to every mode. Some high registers have a private physical copy in certain modes, so the same index can reach a different storage cell after a mode change. Two combinational read ports and one clocked write port serve the datapath.

The block also keeps one current status word, and a saved status word for each exception mode. On an exception request it performs the whole entry sequence in a single clock. It stores the old status word, switches the mode, masks interrupts, leaves 16-bit instruction state, and places the return address in the link register of the new mode. Index 15 is not stored in the register array. Reads of it return the program counter supplied by the core. Writes to it become a branch request.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the status word is 0x000000D3: mode Supervisor (10011) with I (bit 7) and F (bit 6) set and every other bit zero. Every general register reads zero.
- R2: Both read ports are combinational and independent. Indices 0 to 7 reach the same physical registers in every mode.
- R3: When the mode field is FIQ (10001), indices 8 to 14 reach seven private registers. In every other mode, indices 8 to 12 reach the User copies.
- R4: IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011) each have a private index 13 and index 14. User (10000), System (11111) and every unlisted mode code use the User copies.
- R5: A write with wr_en set and an index from 0 to 14 updates the copy selected by the current mode at the next rising edge. Before that edge, reads return the old value.
- R6: Reading index 15 returns pc_in with bits 1:0 cleared when T (bit 5) is 0, and with only bit 0 cleared when T is 1.
- R7: A write to index 15 raises branch_valid in the same cycle. branch_target then carries wr_data aligned as in R6. No general register changes.
- R8: stat_wr_en loads the whole status word at the next edge. The fields are N bit 31, Z bit 30, C bit 29, V bit 28, Q bit 27, I bit 7, F bit 6, T bit 5 and mode bits 4:0. Without a write or an exception entry, the status word holds its value.
- R9: In the five exception modes, saved_rd_data shows that mode's own saved status word, and saved_wr_en loads it at the next edge. In User, System or an unlisted mode code, saved_rd_data equals the current status word and saved_wr_en changes nothing.
- R10: When exc_en is high and exc_mode names an exception mode, the next edge does all of the following at once. It copies the old status word into the target's saved status word. It sets the mode to exc_mode, sets I, clears T and keeps bits 31:8. It writes exc_ret_addr into the target's index 14.
- R11: Entry into FIQ sets F. Entry into any other exception mode leaves F as it was.
- R12: An exc_en with an exc_mode that is not an exception mode is ignored. A valid entry blocks the register, status and saved-status writes of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| pc_in | input | 32 | Current program counter, returned for index 15 |
| branch_valid | output | 1 | Write to index 15 seen this cycle |
| branch_target | output | 32 | Aligned branch address |
| status | output | 32 | Current status word |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | Status word write data |
| saved_rd_data | output | 32 | Saved status word of current mode |
| saved_wr_en | input | 1 | Saved status write enable |
| saved_wr_data | input | 32 | Saved status write data |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret_addr | input | 32 | Return address for the target's index 14 |

## Verification
The two read ports and the branch request are combinational and settle within the cycle their inputs change. Register writes, status writes, saved-status writes and exception entry all become visible exactly one rising edge after the request. The bench applies every stimulus on a falling edge. It checks combinational results 1 ns later, before the next rising edge, which also confirms that a pending write is not yet visible. It checks registered results at the following falling edge. Expected register contents come from a bench model that maps each mode and index to a physical slot, over a sweep of all eight mode codes and all fifteen indices.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] pc_in,
  output logic            branch_valid,
  output logic [XLEN-1:0] branch_target,
  output logic [XLEN-1:0] status,
  input  logic            stat_wr_en,
  input  logic [XLEN-1:0] stat_wr_data,
  output logic [XLEN-1:0] saved_rd_data,
  input  logic            saved_wr_en,
  input  logic [XLEN-1:0] saved_wr_data,
  input  logic            exc_en,
  input  logic [4:0]      exc_mode,
  input  logic [XLEN-1:0] exc_ret_addr
);
  localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010, M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam int SHARED_N = 15;
  localparam int FIQ_N    = 7;
  localparam int SMALL_N  = 4;
  localparam int SAVED_N  = 5;
  localparam logic [XLEN-1:0] RST_STAT = XLEN'({1'b1, 1'b1, 1'b0, M_SVC});
  localparam logic [3:0] PC_IDX = 4'd15;

  typedef enum logic [2:0] {B_USR, B_FIQ, B_IRQ, B_SVC, B_ABT, B_UND} bank_t;

  function automatic bank_t bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return B_FIQ;
      M_IRQ:   return B_IRQ;
      M_SVC:   return B_SVC;
      M_ABT:   return B_ABT;
      M_UND:   return B_UND;
      default: return B_USR;
    endcase
  endfunction

  logic [XLEN-1:0] shared_q [SHARED_N];
  logic [XLEN-1:0] fiq_q    [FIQ_N];
  logic [XLEN-1:0] sp_q     [SMALL_N];
  logic [XLEN-1:0] lr_q     [SMALL_N];
  logic [XLEN-1:0] saved_q  [SAVED_N];
  logic [XLEN-1:0] stat_q;

  bank_t cur_b, exc_b;
  logic [1:0] cur_sb, exc_sb;
  logic [2:0] cur_sv, exc_sv;
  logic       exc_go, cur_small;
  logic [XLEN-1:0] align_mask;

  assign cur_b      = bank_of(stat_q[4:0]);
  assign exc_b      = bank_of(exc_mode);
  assign cur_sb     = 2'(cur_b) - 2'd2;
  assign exc_sb     = 2'(exc_b) - 2'd2;
  assign cur_sv     = 3'(cur_b) - 3'd1;
  assign exc_sv     = 3'(exc_b) - 3'd1;
  assign cur_small  = (cur_b != B_USR) && (cur_b != B_FIQ);
  assign exc_go     = exc_en && (exc_b != B_USR);
  assign align_mask = stat_q[5] ? ~XLEN'(1) : ~XLEN'(3);

  function automatic logic [XLEN-1:0] read_mux(input logic [3:0] idx);
    if (idx == PC_IDX)                      return pc_in & align_mask;
    else if (cur_b == B_FIQ && idx >= 4'd8) return fiq_q[idx[2:0]];
    else if (cur_small && idx >= 4'd13)     return idx[0] ? sp_q[cur_sb] : lr_q[cur_sb];
    else                                    return shared_q[idx];
  endfunction

  assign rd_a_data     = read_mux(rd_a_idx);
  assign rd_b_data     = read_mux(rd_b_idx);
  assign status        = stat_q;
  assign saved_rd_data = (cur_b == B_USR) ? stat_q : saved_q[cur_sv];
  assign branch_valid  = wr_en && (wr_idx == PC_IDX);
  assign branch_target = wr_data & align_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SHARED_N; i++) shared_q[i] <= '0;
      for (int i = 0; i < FIQ_N; i++)    fiq_q[i]    <= '0;
      for (int i = 0; i < SMALL_N; i++) begin
        sp_q[i] <= '0;
        lr_q[i] <= '0;
      end
      for (int i = 0; i < SAVED_N; i++)  saved_q[i]  <= '0;
      stat_q <= RST_STAT;
    end else if (exc_go) begin
      saved_q[exc_sv] <= stat_q;
      stat_q <= {stat_q[XLEN-1:8], 1'b1, stat_q[6] | (exc_b == B_FIQ), 1'b0, exc_mode};
      if (exc_b == B_FIQ) fiq_q[FIQ_N-1] <= exc_ret_addr;
      else                lr_q[exc_sb]   <= exc_ret_addr;
    end else begin
      if (wr_en && wr_idx != PC_IDX) begin
        if (cur_b == B_FIQ && wr_idx >= 4'd8) fiq_q[wr_idx[2:0]] <= wr_data;
        else if (cur_small && wr_idx >= 4'd13) begin
          if (wr_idx[0]) sp_q[cur_sb] <= wr_data;
          else           lr_q[cur_sb] <= wr_data;
        end else shared_q[wr_idx] <= wr_data;
      end
      if (saved_wr_en && cur_b != B_USR) saved_q[cur_sv] <= saved_wr_data;
      if (stat_wr_en) stat_q <= stat_wr_data;
    end
  end

  a_r10_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go |=> status[4:0] == $past(exc_mode) && status[7] && !status[5]
               && status[XLEN-1:8] == $past(status[XLEN-1:8]));

  a_r10_entry_saved: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go |=> saved_rd_data == $past(status));

  a_r10_entry_link: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go && exc_b != B_FIQ |=> lr_q[$past(exc_sb)] == $past(exc_ret_addr));

  a_r11_fiq_masks_fast: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go && exc_b == B_FIQ |=> status[6] && fiq_q[FIQ_N-1] == $past(exc_ret_addr));

  a_r11_other_keeps_fast: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go && exc_b != B_FIQ |=> status[6] == $past(status[6]));

  a_r8_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_go && !stat_wr_en |=> status == $past(status));

  a_r7_branch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |-> (status[5] ? !branch_target[0] : branch_target[1:0] == 2'b00));

  a_r12_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go && wr_en && wr_idx < 4'd8 |=> shared_q[$past(wr_idx)] == $past(shared_q[wr_idx]));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_in = '0;
  logic        wr_en = 1'b0, stat_wr_en = 1'b0, saved_wr_en = 1'b0, exc_en = 1'b0;
  logic        branch_valid;
  logic [31:0] branch_target, status, saved_rd_data;
  logic [31:0] stat_wr_data = '0, saved_wr_data = '0, exc_ret_addr = '0;
  logic [4:0]  exc_mode = '0;

  banked_regfile uut (
    .clk, .rst_n, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data, .pc_in, .branch_valid, .branch_target,
    .status, .stat_wr_en, .stat_wr_data, .saved_rd_data, .saved_wr_en,
    .saved_wr_data, .exc_en, .exc_mode, .exc_ret_addr
  );

  int checks = 0, fails = 0;
  logic [31:0] model [31];
  logic [31:0] msav  [6];
  localparam logic [4:0] MODES [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

  function automatic int bk(logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int slot(logic [4:0] m, int i);
    int b = bk(m);
    if (b == 1 && i >= 8) return 15 + i - 8;
    if (b >= 2 && i >= 13) return 22 + (b - 2) * 2 + (i - 13);
    return i;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_stat(logic [31:0] v);
    stat_wr_en = 1'b1; stat_wr_data = v;
    @(negedge clk);
    stat_wr_en = 1'b0;
  endtask

  task automatic wreg(int i, logic [31:0] v);
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_all(string tag, logic [4:0] m);
    for (int i = 0; i < 15; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'((i + 5) % 15);
      #1;
      chk(tag, rd_a_data, model[slot(m, i)]);
      chk(tag, rd_b_data, model[slot(m, (i + 5) % 15)]);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 31; i++) model[i] = '0;
    for (int i = 0; i < 6; i++) msav[i] = '0;
    @(negedge clk);
    chk("R1 status in reset", status, 32'h0000_00D3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status, 32'h0000_00D3);
    read_all("R1 registers zero", 5'h13);

    // R5: write not visible before the edge, visible after
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1111_2222; rd_a_idx = 4'd3;
    #1 chk("R5 old value before edge", rd_a_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; model[3] = 32'h1111_2222;
    #1 chk("R5 new value after edge", rd_a_data, 32'h1111_2222);
    @(negedge clk);

    // Sweep writes across all mode codes
    for (int mi = 0; mi < 8; mi++) begin
      set_stat({24'h0, 3'b110, MODES[mi]});
      for (int i = 0; i < 15; i++) begin
        logic [31:0] v = {8'(mi + 1), 8'(i), 16'hC35A ^ 16'(mi * 37 + i)};
        wreg(i, v);
        model[slot(MODES[mi], i)] = v;
      end
    end
    for (int mi = 0; mi < 8; mi++) begin
      set_stat({24'h0, 3'b110, MODES[mi]});
      read_all("R2 R3 R4 banked read", MODES[mi]);
    end

    // R6: program counter read
    set_stat(32'h0000_0013);
    pc_in = 32'h1234_5677; rd_a_idx = 4'd15; rd_b_idx = 4'd15;
    #1 chk("R6 pc read T=0", rd_a_data, 32'h1234_5674);
    chk("R6 pc read port b", rd_b_data, 32'h1234_5674);
    @(negedge clk);
    set_stat(32'h0000_0033);
    rd_a_idx = 4'd15;
    #1 chk("R6 pc read T=1", rd_a_data, 32'h1234_5676);
    @(negedge clk);

    // R7: write to index 15
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h8000_0003;
    #1 chk("R7 branch valid", 32'(branch_valid), 32'd1);
    chk("R7 branch target T=1", branch_target, 32'h8000_0002);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7 branch drops", 32'(branch_valid), 32'd0);
    read_all("R7 registers untouched", 5'h13);
    set_stat(32'h0000_0013);
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h8000_0007;
    #1 chk("R7 branch target T=0", branch_target, 32'h8000_0004);
    @(negedge clk);
    wr_en = 1'b0;

    // R8: full status word load and hold
    set_stat(32'hF800_00FF);
    chk("R8 status load", status, 32'hF800_00FF);
    @(negedge clk);
    chk("R8 status holds", status, 32'hF800_00FF);

    // R9: saved status per exception mode
    for (int mi = 1; mi <= 5; mi++) begin
      set_stat({24'h0, 3'b110, MODES[mi]});
      saved_wr_en = 1'b1; saved_wr_data = 32'h5A5A_0000 | 32'(mi);
      @(negedge clk);
      saved_wr_en = 1'b0;
      msav[mi] = 32'h5A5A_0000 | 32'(mi);
      chk("R9 saved write read", saved_rd_data, msav[mi]);
    end
    for (int k = 0; k < 3; k++) begin
      logic [4:0] m = (k == 0) ? 5'h10 : (k == 1) ? 5'h1F : 5'h05;
      set_stat({24'h0, 3'b000, m});
      #1 chk("R9 no saved reg reads status", saved_rd_data, {27'h0, m});
      saved_wr_en = 1'b1; saved_wr_data = 32'hDEAD_BEEF;
      @(negedge clk);
      saved_wr_en = 1'b0;
      chk("R9 no saved reg after write", saved_rd_data, {27'h0, m});
    end
    for (int mi = 1; mi <= 5; mi++) begin
      set_stat({24'h0, 3'b110, MODES[mi]});
      chk("R9 saved regs unchanged", saved_rd_data, msav[mi]);
    end

    // R10 R11: exception entry into each exception mode
    for (int mi = 1; mi <= 5; mi++) begin
      logic [31:0] ret = 32'hC0DE_0000 | 32'(mi << 4);
      set_stat(32'hF800_0030);
      exc_en = 1'b1; exc_mode = MODES[mi]; exc_ret_addr = ret;
      @(negedge clk);
      exc_en = 1'b0;
      model[slot(MODES[mi], 14)] = ret;
      chk("R10 R11 entry status", status,
          32'hF800_0080 | ((mi == 1) ? 32'h40 : 32'h0) | {27'h0, MODES[mi]});
      chk("R10 saved old status", saved_rd_data, 32'hF800_0030);
      rd_a_idx = 4'd14;
      #1 chk("R10 link register", rd_a_data, ret);
      @(negedge clk);
    end
    set_stat(32'hF800_0070);
    exc_en = 1'b1; exc_mode = 5'h12; exc_ret_addr = 32'hABCD_0008;
    @(negedge clk);
    exc_en = 1'b0; model[slot(5'h12, 14)] = 32'hABCD_0008;
    chk("R11 F kept on IRQ entry", status, 32'hF800_00D2);
    read_all("R10 registers after entry", 5'h12);

    // R12: invalid target ignored, valid entry blocks same-cycle writes
    set_stat(32'h0000_0010);
    exc_en = 1'b1; exc_mode = 5'h1F; exc_ret_addr = 32'h7777_7777;
    @(negedge clk);
    exc_en = 1'b0;
    chk("R12 invalid entry ignored", status, 32'h0000_0010);
    read_all("R12 registers after invalid entry", 5'h10);
    exc_en = 1'b1; exc_mode = 5'h12; exc_ret_addr = 32'h0000_4444;
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'hBAD0_BAD0;
    stat_wr_en = 1'b1; stat_wr_data = 32'h0000_001F;
    saved_wr_en = 1'b1; saved_wr_data = 32'hBAD1_BAD1;
    @(negedge clk);
    exc_en = 1'b0; wr_en = 1'b0; stat_wr_en = 1'b0; saved_wr_en = 1'b0;
    model[slot(5'h12, 14)] = 32'h0000_4444;
    chk("R12 entry wins over status write", status, 32'h0000_0092);
    chk("R12 entry wins over saved write", saved_rd_data, 32'h0000_0010);
    read_all("R12 register write blocked", 5'h12);

    summary();
  end
endmodule